// File: doc/BRIEF.md
# Packed VLAN Membership Table with Byte-Register Access

This block keeps a 4096-entry VLAN table of 13-bit entries. Entries are packed four to a 52-bit word, so the store holds 1024 words. A host on a byte-wide register bus never touches the store directly. It works through a 52-bit staging buffer that appears as seven data registers, a control register that picks the table and the direction, and a low address byte.

Writing the low address byte starts the transfer. A read copies the addressed word into the buffer. A write copies the buffer into the addressed word. To change a single VLAN entry, the host reads the word that holds it, rewrites only the bits of that entry in the buffer, and writes the word back to the same address.

A VLAN ID maps to word `VID[11:2]` and to slot `VID[1:0]` within that word.

Top module: `vlan_ind_tbl`

## Requirements
- R1: After reset, `busy_o` is 0, every data register reads 0, and every table word reads back as all zeros.
- R2: Control byte bits are decoded as follows. Bit 4 set means read and bit 4 clear means write. Bits [3:2] = 01 select the VLAN table. Bits [1:0] are word address bits [9:8]. Writing register 111 supplies word address bits [7:0] and triggers the operation. A read loads the buffer on the clock after the trigger.
- R3: A write operation (for example control 0x04) stores the whole 52-bit buffer into the addressed word.
- R4: The buffer is big-endian across registers 114 to 120. Register 120 holds bits [7:0], 119 holds [15:8], 118 holds [23:16], 117 holds [31:24], 116 holds [39:32] and 115 holds [47:40]. Register 114 holds bits [51:48] in its low nibble, and its upper nibble always reads 0.
- R5: Slot s of a word occupies word bits [13s+12:13s]. For slot 2, entry bits 12..6 are register 116 bits [6:0] and entry bits 5..0 are register 117 bits [7:2]. A read-modify-write of one slot leaves the other three slots unchanged.
- R6: `busy_o` rises on the clock after an accepted trigger and falls one clock later. A trigger that arrives while `busy_o` is 1 is ignored.
- R7: Writing the data registers changes only the buffer, never table memory. A word that has never been written reads as zero.
- R8: A trigger is ignored when control bits [3:2] are not 01. In that case `busy_o` stays 0, the buffer is kept and the table is kept.
- R9: Registers 110 and 111 read back the last byte written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register number for both read and write |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i`, combinational |
| busy_o | output | 1 | A table transfer is in progress |

## Verification
The assertions assume one register write at most per clock and a stable `reg_addr_i` while a readback is sampled. They also assume the host does not write the data registers in the cycle where a read loads the buffer, because the load takes priority over a host write in that cycle. The stimulus drives every access at the falling edge and waits one idle clock after each trigger before it touches the buffer. The only deliberate overlap is the back-to-back trigger that exercises the busy lockout.

// File: rtl/vlan_tbl_pkg.sv
package vlan_tbl_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ENTRY_W   = 13;
  localparam int unsigned SLOTS     = 4;
  localparam int unsigned WORD_W    = ENTRY_W * SLOTS;
  localparam int unsigned WORD_AW   = 10;
  localparam int unsigned NWORDS    = 1 << WORD_AW;
  localparam int unsigned NDATA     = (WORD_W + BYTE_W - 1) / BYTE_W;
  localparam logic [7:0]  REG_CTRL  = 8'd110;
  localparam logic [7:0]  REG_ALO   = 8'd111;
  localparam logic [7:0]  REG_DHI   = 8'd114;
  localparam logic [1:0]  SEL_VLAN  = 2'b01;

  typedef enum logic {OP_WRITE = 1'b0, OP_READ = 1'b1} op_e;
endpackage

// File: rtl/vlan_reg_if.sv
module vlan_reg_if
  import vlan_tbl_pkg::*;
#(
  parameter int unsigned AW = WORD_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [7:0]    addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    ctrl_o,
  output logic [7:0]    alo_o,
  output logic          busy_o,
  output logic [AW-1:0] op_addr_o,
  output logic          mem_we_o,
  output logic          buf_ld_o
);
  localparam int unsigned HI_W = AW - BYTE_W;

  logic    ctrl_hit, alo_hit, accept;
  logic    busy_q;
  op_e     op_q;
  logic [7:0] ctrl_q, alo_q;
  logic [AW-1:0] op_addr_q;

  assign ctrl_hit = we_i && (addr_i == REG_CTRL);
  assign alo_hit  = we_i && (addr_i == REG_ALO);
  assign accept   = alo_hit && !busy_q && (ctrl_q[3:2] == SEL_VLAN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      alo_q     <= '0;
      busy_q    <= 1'b0;
      op_q      <= OP_WRITE;
      op_addr_q <= '0;
    end else begin
      if (ctrl_hit) ctrl_q <= wdata_i;
      if (alo_hit)  alo_q  <= wdata_i;
      busy_q <= accept;
      if (accept) begin
        op_q      <= op_e'(ctrl_q[4]);
        op_addr_q <= {ctrl_q[HI_W-1:0], wdata_i};
      end
    end
  end

  assign ctrl_o    = ctrl_q;
  assign alo_o     = alo_q;
  assign busy_o    = busy_q;
  assign op_addr_o = op_addr_q;
  assign mem_we_o  = busy_q && (op_q == OP_WRITE);
  assign buf_ld_o  = busy_q && (op_q == OP_READ);
endmodule

// File: rtl/vlan_stage_buf.sv
module vlan_stage_buf
  import vlan_tbl_pkg::*;
#(
  parameter int unsigned W     = WORD_W,
  parameter int unsigned NREG  = NDATA,
  parameter logic [7:0]  FIRST = REG_DHI
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [7:0]   addr_i,
  input  logic [7:0]   wdata_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_word_i,
  output logic [W-1:0] word_o,
  output logic [7:0]   rdata_o,
  output logic         hit_o
);
  localparam int unsigned EXT_W = NREG * BYTE_W;

  logic [EXT_W-1:0] ld_ext, buf_q;
  assign ld_ext = EXT_W'(ld_word_i);

  // byte i = bits [8i+7:8i], register FIRST+NREG-1-i (big-endian)
  for (genvar i = 0; i < NREG; i++) begin : g_byte
    localparam int unsigned VB   = (W - BYTE_W*i) >= BYTE_W ? BYTE_W : W - BYTE_W*i;
    localparam logic [7:0]  MASK = 8'((9'd1 << VB) - 9'd1);
    localparam logic [7:0]  RNUM = FIRST + 8'(NREG - 1 - i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          buf_q[BYTE_W*i +: BYTE_W] <= '0;
      else if (ld_i)                        buf_q[BYTE_W*i +: BYTE_W] <= ld_ext[BYTE_W*i +: BYTE_W];
      else if (we_i && addr_i == RNUM)      buf_q[BYTE_W*i +: BYTE_W] <= wdata_i & MASK;
    end
  end

  always_comb begin
    rdata_o = '0;
    hit_o   = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      if (addr_i == FIRST + 8'(NREG - 1 - i)) begin
        rdata_o = buf_q[BYTE_W*i +: BYTE_W];
        hit_o   = 1'b1;
      end
    end
  end

  assign word_o = buf_q[W-1:0];
endmodule

// File: rtl/vlan_word_mem.sv
module vlan_word_mem
  import vlan_tbl_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned AW = WORD_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0]     mem_q [DEPTH];
  logic [DEPTH-1:0] vld_q;  // unwritten words read as zero

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   vld_q <= '0;
    else if (we_i) vld_q[addr_i] <= 1'b1;
  end

  assign rdata_o = vld_q[addr_i] ? mem_q[addr_i] : '0;
endmodule

// File: rtl/vlan_ind_tbl.sv
module vlan_ind_tbl
  import vlan_tbl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [7:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       busy_o
);
  logic [7:0]         ctrl_q, alo_q, buf_rdata;
  logic               buf_hit, mem_we, buf_ld;
  logic [WORD_AW-1:0] op_addr;
  logic [WORD_W-1:0]  buf_word, mem_rdata;

  vlan_reg_if #(.AW(WORD_AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .ctrl_o(ctrl_q), .alo_o(alo_q), .busy_o,
    .op_addr_o(op_addr), .mem_we_o(mem_we), .buf_ld_o(buf_ld)
  );

  vlan_stage_buf #(.W(WORD_W), .NREG(NDATA), .FIRST(REG_DHI)) u_buf (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .ld_i(buf_ld), .ld_word_i(mem_rdata),
    .word_o(buf_word), .rdata_o(buf_rdata), .hit_o(buf_hit)
  );

  vlan_word_mem #(.W(WORD_W), .AW(WORD_AW)) u_mem (
    .clk_i, .rst_ni,
    .we_i(mem_we), .addr_i(op_addr), .wdata_i(buf_word), .rdata_o(mem_rdata)
  );

  always_comb begin
    if (reg_addr_i == REG_CTRL)     reg_rdata_o = ctrl_q;
    else if (reg_addr_i == REG_ALO) reg_rdata_o = alo_q;
    else if (buf_hit)               reg_rdata_o = buf_rdata;
    else                            reg_rdata_o = '0;
  end
endmodule

// File: rtl/vlan_tbl_chk.sv
module vlan_tbl_chk
  import vlan_tbl_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [7:0] reg_addr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       busy_o,
  input logic [7:0] ctrl_q,
  input logic       mem_we,
  input logic       buf_ld
);
  // R6
  busy_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);
  // R6
  trig_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == REG_ALO && !busy_o && ctrl_q[3:2] == SEL_VLAN) |=> busy_o);
  // R8
  bad_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == REG_ALO && ctrl_q[3:2] != SEL_VLAN && !busy_o) |=> !busy_o);
  // R7
  mem_we_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we) |-> $past(reg_we_i && reg_addr_i == REG_ALO));
  // R2
  buf_ld_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_ld) |-> $past(reg_we_i && reg_addr_i == REG_ALO && ctrl_q[4]));
  // R4
  hi_nibble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == REG_DHI) |-> reg_rdata_o[7:4] == 4'h0);
  // R9
  ctrl_rb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == REG_CTRL) |=>
      (reg_addr_i != REG_CTRL || reg_rdata_o == $past(reg_wdata_i)));
endmodule

bind vlan_ind_tbl vlan_tbl_chk u_chk (
  .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .busy_o,
  .ctrl_q, .mem_we, .buf_ld
);

// File: tb/tb_vlan_ind_tbl.sv
module tb_vlan_ind_tbl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] addr = 8'd0, wdata = 8'd0, rdata;
  logic       busy;
  int checks = 0, errors = 0;

  vlan_ind_tbl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .busy_o(busy)
  );

  always #10 clk = ~clk;

  // kind: 0 write, 1 check readback, 2 idle clock
  localparam int NV = 37;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'd114, 8'hA5}, {2'd1, 8'd114, 8'h05},                       // R4
    {2'd0, 8'd115, 8'h11}, {2'd0, 8'd116, 8'h22}, {2'd0, 8'd117, 8'h33},
    {2'd0, 8'd118, 8'h44}, {2'd0, 8'd119, 8'h55}, {2'd0, 8'd120, 8'h66},
    {2'd1, 8'd115, 8'h11}, {2'd1, 8'd116, 8'h22}, {2'd1, 8'd117, 8'h33},   // R4
    {2'd1, 8'd118, 8'h44}, {2'd1, 8'd119, 8'h55}, {2'd1, 8'd120, 8'h66},
    {2'd0, 8'd110, 8'h04}, {2'd1, 8'd110, 8'h04},                       // R9
    {2'd0, 8'd111, 8'h03}, {2'd1, 8'd111, 8'h03}, {2'd2, 8'd0, 8'h00},    // R3
    {2'd0, 8'd114, 8'h00}, {2'd0, 8'd115, 8'h00}, {2'd0, 8'd116, 8'h00},
    {2'd0, 8'd117, 8'h00}, {2'd0, 8'd118, 8'h00}, {2'd0, 8'd119, 8'h00},
    {2'd0, 8'd120, 8'h00}, {2'd1, 8'd117, 8'h00},
    {2'd0, 8'd110, 8'h14}, {2'd0, 8'd111, 8'h03}, {2'd2, 8'd0, 8'h00},    // R2
    {2'd1, 8'd114, 8'h05}, {2'd1, 8'd115, 8'h11}, {2'd1, 8'd116, 8'h22},
    {2'd1, 8'd117, 8'h33}, {2'd1, 8'd118, 8'h44}, {2'd1, 8'd119, 8'h55},
    {2'd1, 8'd120, 8'h66}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic load_buf(input logic [51:0] w);
    for (int r = 114; r <= 120; r++) wr(8'(r), w[8*(120-r) +: 8] & ((r == 114) ? 8'h0F : 8'hFF));
  endtask

  task automatic chk_buf(input string tag, input logic [51:0] w);
    for (int r = 114; r <= 120; r++) rd_chk(tag, 8'(r), w[8*(120-r) +: 8] & ((r == 114) ? 8'h0F : 8'hFF));
  endtask

  task automatic op(input logic [7:0] c, input logic [7:0] lo);
    wr(8'd110, c); wr(8'd111, lo); idle();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [51:0] w;
    #35 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {7'd0, busy}, 8'h00);
    chk_buf("R1 buf", 52'd0);
    op(8'h17, 8'hFF);
    chk_buf("R1 word 1023", 52'd0);

    // vector walk: R2 R3 R4 R9
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][17:16])
        2'd0: wr(VEC[i][15:8], VEC[i][7:0]);
        2'd1: rd_chk("R2/R3/R4/R9 vec", VEC[i][15:8], VEC[i][7:0]);
        default: idle();
      endcase
    end

    // R5 single-slot read-modify-write of VID 10 (word 2, slot 2)
    load_buf('1);
    op(8'h04, 8'h02);
    load_buf(52'd0);
    op(8'h14, 8'h02);
    rd_chk("R5 pre", 8'd116, 8'hFF);
    wr(8'd116, (8'hFF & 8'h80) | 8'h2A);
    wr(8'd117, (8'hFF & 8'h03) | 8'hF0);
    op(8'h04, 8'h02);
    load_buf(52'd0);
    op(8'h14, 8'h02);
    w = '1; w[38:26] = 13'h0ABC;
    chk_buf("R5 slot2", w);

    // R2 high address bits from control: word 1023 vs word 255
    load_buf(52'h9_8765_4321_ABCD);
    op(8'h07, 8'hFF);
    op(8'h14, 8'hFF);
    chk_buf("R2 word 255", 52'd0);
    op(8'h17, 8'hFF);
    chk_buf("R2 word 1023", 52'h9_8765_4321_ABCD);

    // R6 busy timing and lockout
    load_buf(52'h1_1111_2222_3333);
    wr(8'd110, 8'h04); wr(8'd111, 8'h05);
    chk("R6 busy high", {7'd0, busy}, 8'h01);
    idle();
    chk("R6 busy low", {7'd0, busy}, 8'h00);
    load_buf(52'h2_4444_5555_6666);
    op(8'h04, 8'h07);
    wr(8'd110, 8'h14);
    wr(8'd111, 8'h05); wr(8'd111, 8'h07); idle();
    chk_buf("R6 lockout", 52'h1_1111_2222_3333);
    rd_chk("R9 addr lo", 8'd111, 8'h07);

    // R7 data writes never reach memory
    load_buf(52'hF_0F0F_0F0F_0F0F);
    op(8'h14, 8'h07);
    chk_buf("R7 word7", 52'h2_4444_5555_6666);
    load_buf(52'hF_0F0F_0F0F_0F0F);
    op(8'h14, 8'h09);
    chk_buf("R7 fresh word", 52'd0);

    // R8 unsupported table select
    load_buf(52'hC_CCCC_CCCC_CCCC);
    wr(8'd110, 8'h18); wr(8'd111, 8'h07);
    chk("R8 no busy", {7'd0, busy}, 8'h00);
    idle();
    chk_buf("R8 buf kept", 52'hC_CCCC_CCCC_CCCC);
    op(8'h08, 8'h07);
    op(8'h14, 8'h07);
    chk_buf("R8 mem kept", 52'h2_4444_5555_6666);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule